// File: doc/BRIEF.md
# Packed Lane Logical Right Shifter

This block is a purely combinational vector datapath element. It takes a 128-bit data vector, divides it into equal-width lanes (16 bits by default), and shifts every lane right by one shared count. Each lane is shifted separately, and bits never move from one lane into the next. Bit positions emptied at the top of a lane are filled with zeros.

The shift count comes from one of two places, picked by a select input. It is either the low 64 bits of a second 128-bit vector or an 8-bit immediate. The whole count is compared with the largest useful shift for a lane. If it is larger, every lane of the result is zero; the count is never reduced modulo the lane width. Each result lane sits in the same bit positions as the data lane it came from, so the result can be written straight back over the first operand.

Top module: `vec_lane_srl`

## Requirements
- R1: When the count is in range, each lane of `res_vec` equals the matching lane of `data_vec` shifted right by the count, with zeros filled into the vacated high bits.
- R2: When the count is at least the lane width (16 by default), every bit of `res_vec` is 0.
- R3: When `cnt_from_imm` is 0, the count is `cnt_vec[63:0]`, and `cnt_vec[127:64]` has no effect on `res_vec`.
- R4: When `cnt_from_imm` is 1, the count is `imm_cnt` read as an unsigned value and zero-extended, and `cnt_vec` has no effect on `res_vec`.
- R5: The full 64-bit count is compared, so a count with any bit above bit 3 set clears the result (for example 2^32 or 2^63). It is not truncated to its low bits.
- R6: Lane i occupies bits 16i+15:16i of both `data_vec` and `res_vec`, and no bit of one lane reaches another lane.
- R7: A count of 0 passes `data_vec` unchanged to `res_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_vec | input | 128 | Packed lanes to be shifted |
| cnt_vec | input | 128 | Second vector; bits 63:0 give the register-form count |
| imm_cnt | input | 8 | Immediate-form unsigned count |
| cnt_from_imm | input | 1 | 1 selects `imm_cnt`, 0 selects `cnt_vec[63:0]` |
| res_vec | output | 128 | Shifted lanes, same positions as `data_vec` |

## Verification
The shifter is driven with data patterns that separate the lanes in different ways: all ones, a walking pattern that is different in every lane, a single top bit per lane, and a value with only the low bit of each lane set. Across these patterns, a bit that leaks into the neighbouring lane, a wrong fill value, or a lane order swap each produces a visible difference. Counts are tried at 0, 1, 15, 16 and 255, and also at values with bits set only at 2^4, 2^32 or 2^63. These values tell a full 64-bit compare apart from a truncated count and locate the exact clear threshold. The same counts are also presented with the other count source holding a conflicting value, and with garbage in `cnt_vec[127:64]`, which shows that the select input and the ignored bits really are ignored.

// File: rtl/vec_srl_pkg.sv
package vec_srl_pkg;

    localparam int VEC_W = 128;
    localparam int CNT_W = 64;
    localparam int IMM_W = 8;
    // Room for any lane width up to 64 bits.
    localparam int AMT_W = 7;

    typedef struct packed {
        logic             kill;   // count too large: clear lane
        logic [AMT_W-1:0] amt;    // in-range shift amount
    } shift_ctl_t;

    typedef enum logic {
        SRC_VEC = 1'b0,
        SRC_IMM = 1'b1
    } cnt_src_e;

    function automatic logic [CNT_W-1:0] widen_imm(input logic [IMM_W-1:0] v);
        return {{(CNT_W-IMM_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/vec_srl_cnt_sel.sv
module vec_srl_cnt_sel
    import vec_srl_pkg::*;
(
    input  logic [CNT_W-1:0] vec_lo,
    input  logic [IMM_W-1:0] imm,
    input  cnt_src_e         src,
    output logic [CNT_W-1:0] count
);

    always_comb begin
        unique case (src)
            SRC_IMM: count = widen_imm(imm);
            default: count = vec_lo;
        endcase
    end

    // An immediate count can never exceed 8 bits of magnitude.
    always_comb begin
        if (src == SRC_IMM)
            assert_imm_narrow_R4: assert (count[CNT_W-1:IMM_W] == '0)
                else $error("immediate count has upper bits set");
    end

endmodule

// File: rtl/vec_srl_cnt_range.sv
module vec_srl_cnt_range
    import vec_srl_pkg::*;
#(
    parameter int LANE_W = 16
)(
    input  logic [CNT_W-1:0] count,
    output shift_ctl_t       ctl
);

    localparam logic [CNT_W-1:0] MAX_SH = CNT_W'(LANE_W - 1);

    always_comb begin
        ctl.kill = (count > MAX_SH);
        ctl.amt  = ctl.kill ? '0 : count[AMT_W-1:0];
    end

    always_comb begin
        if (!ctl.kill)
            assert_amt_in_range_R2: assert (int'(ctl.amt) < LANE_W)
                else $error("shift amount escaped the lane range");
    end

endmodule

// File: rtl/vec_srl_lane.sv
module vec_srl_lane
    import vec_srl_pkg::*;
#(
    parameter int LANE_W = 16
)(
    input  logic [LANE_W-1:0] din,
    input  shift_ctl_t        ctl,
    output logic [LANE_W-1:0] dout
);

    always_comb begin
        if (ctl.kill)
            dout = '0;
        else
            dout = din >> ctl.amt;
    end

    always_comb begin
        assert_no_growth_R1: assert (dout <= din)
            else $error("logical shift increased a lane");
        if (ctl.kill)
            assert_lane_cleared_R2: assert (dout == '0)
                else $error("lane not cleared on large count");
        if (!ctl.kill && ctl.amt == '0)
            assert_zero_passes_R7: assert (dout == din)
                else $error("zero count changed a lane");
    end

endmodule

// File: rtl/vec_lane_srl.sv
module vec_lane_srl
    import vec_srl_pkg::*;
#(
    parameter int LANE_W = 16
)(
    input  logic [VEC_W-1:0] data_vec,
    input  logic [VEC_W-1:0] cnt_vec,
    input  logic [IMM_W-1:0] imm_cnt,
    input  logic             cnt_from_imm,
    output logic [VEC_W-1:0] res_vec
);

    localparam int NLANES = VEC_W / LANE_W;

    logic [CNT_W-1:0] count;
    shift_ctl_t       ctl;
    cnt_src_e         src;

    assign src = cnt_from_imm ? SRC_IMM : SRC_VEC;

    vec_srl_cnt_sel u_sel (
        .vec_lo (cnt_vec[CNT_W-1:0]),
        .imm    (imm_cnt),
        .src    (src),
        .count  (count)
    );

    vec_srl_cnt_range #(.LANE_W(LANE_W)) u_range (
        .count (count),
        .ctl   (ctl)
    );

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        vec_srl_lane #(.LANE_W(LANE_W)) u_lane (
            .din  (data_vec[g*LANE_W +: LANE_W]),
            .ctl  (ctl),
            .dout (res_vec[g*LANE_W +: LANE_W])
        );
    end

    // A right shift that stays inside lanes can only drop set bits.
    always_comb begin
        assert_no_new_bits_R6: assert ($countones(res_vec) <= $countones(data_vec))
            else $error("result gained set bits");
    end

endmodule

// File: tb/test_vec_lane_srl.sv
module test_vec_lane_srl;

    logic         clk = 1'b0;
    logic [127:0] data_vec, cnt_vec;
    logic [7:0]   imm_cnt;
    logic         cnt_from_imm;
    logic [127:0] res_vec;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    vec_lane_srl i_vec_lane_srl (
        .data_vec     (data_vec),
        .cnt_vec      (cnt_vec),
        .imm_cnt      (imm_cnt),
        .cnt_from_imm (cnt_from_imm),
        .res_vec      (res_vec)
    );

    typedef struct packed {
        logic [127:0] a;
        logic [127:0] b;
        logic [7:0]   imm;
        logic         use_imm;
    } stim_t;

    localparam stim_t TBL [12] = '{
        '{128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 128'd1,  8'd0,   1'b0},
        '{128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 128'd4,  8'd0,   1'b0},
        '{128'h8000_8000_8000_8000_8000_8000_8000_8000, 128'd15, 8'd0,   1'b0},
        '{128'h8000_8000_8000_8000_8000_8000_8000_8000, 128'd16, 8'd0,   1'b0},
        '{128'h0001_0001_0001_0001_0001_0001_0001_0001, 128'd0,  8'd1,   1'b1},
        '{128'hA5A5_5A5A_F00F_0FF0_1234_8765_DEAD_BEEF, 128'd0,  8'd7,   1'b1},
        '{128'hA5A5_5A5A_F00F_0FF0_1234_8765_DEAD_BEEF, 128'd0,  8'd16,  1'b1},
        '{128'hA5A5_5A5A_F00F_0FF0_1234_8765_DEAD_BEEF, 128'd0,  8'd255, 1'b1},
        '{128'hFFFF_0000_FFFF_0000_FFFF_0000_FFFF_0000, 128'd8,  8'd0,   1'b0},
        '{128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 128'd12, 8'd3,   1'b0},
        '{128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 128'd12, 8'd3,   1'b1},
        '{128'h7FFF_7FFF_7FFF_7FFF_7FFF_7FFF_7FFF_7FFF, 128'd14, 8'd0,   1'b0}
    };

    function automatic logic [127:0] model(input stim_t s);
        logic [63:0]  c;
        logic [127:0] r;
        c = s.use_imm ? {56'd0, s.imm} : s.b[63:0];
        r = '0;
        for (int i = 0; i < 8; i++)
            if (c <= 64'd15)
                r[i*16 +: 16] = s.a[i*16 +: 16] >> c[3:0];
        return r;
    endfunction

    task automatic apply(input stim_t s, input string req);
        logic [127:0] exp_v;
        @(negedge clk);
        data_vec     = s.a;
        cnt_vec      = s.b;
        imm_cnt      = s.imm;
        cnt_from_imm = s.use_imm;
        exp_v        = model(s);
        #2;
        n_chk++;
        if (res_vec !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, res_vec, exp_v);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // Idle state: all-zero inputs give all-zero output (R1).
        apply('{128'd0, 128'd0, 8'd0, 1'b0}, "R1 idle");
        // Main table: R1 shifts, R2 clears, R4 immediate, R6 lanes.
        for (int k = 0; k < 12; k++)
            apply(TBL[k], "R1/R2/R4/R6 table");
        // R7: zero count passes through.
        apply('{128'hDEAD_BEEF_0123_4567_89AB_CDEF_5555_AAAA, 128'd0, 8'd0, 1'b0}, "R7 zero count");
        // R3: upper half of the count vector ignored.
        apply('{128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
                {64'hFFFF_FFFF_FFFF_FFFF, 64'd3}, 8'd0, 1'b0}, "R3 upper count bits ignored");
        // R4: count vector ignored in immediate form.
        apply('{128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
                128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 8'd2, 1'b1}, "R4 vector ignored");
        // R5: large counts not truncated.
        apply('{128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, {64'd0, 64'h1_0000_0000}, 8'd0, 1'b0}, "R5 count 2^32");
        apply('{128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, {64'd0, 64'h8000_0000_0000_0001}, 8'd0, 1'b0}, "R5 count 2^63+1");
        apply('{128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, {64'd0, 64'h0000_0000_0000_0101}, 8'd0, 1'b0}, "R5 count 257");
        // R2: immediate 16 with a small vector count present.
        apply('{128'h1234_1234_1234_1234_1234_1234_1234_1234, 128'd1, 8'd16, 1'b1}, "R2 imm 16");
        finish_run();
    end

endmodule